// File: doc/BRIEF.md
# I2C Master Register and Interrupt Unit

This block is the software-facing front end of an I2C master. A host issues single-cycle 32-bit reads and writes at byte offsets. Writes configure the interrupt enables, the DMA enables, the byte count, the control word and the two 10-bit addresses. Reads return those values, the status word, a revision constant and an encoded interrupt vector. The block does not move bus data itself. A separate transfer sequencer reports events through one-cycle pulse inputs, and those pulses set status bits here. The sequencer also clears the receive-ready and transmit-ready bits through dedicated pulses once it has served them.

The status word is combined with the enable mask to drive a single interrupt line. Two DMA request lines, one for receive and one for transmit, follow the matching ready bits when DMA is switched on for that direction. Turning DMA on for a direction also drops that direction's ready interrupt enable, so the same event never raises both an interrupt and a DMA request. Reading the vector offset returns a code for the lowest pending enabled event and acknowledges that event in the same access.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: On synchronous reset, every register and the status word are zero, and `irq`, `drq_rx` and `drq_tx` are low. A read of offset 0x00 returns the `REV` parameter, zero-extended. Read data appears on `rdata` one cycle after `rd_en` and holds until the next read.
- R2: Writes to offsets 0x00 (revision), 0x0C (vector) and 0x10 (module status) change no register and no status bit.
- R3: Each event pulse sets its own status bit: `ev_nack` sets bit 1, `ev_acc_rdy` bit 2, `ev_rx_rdy` bit 3, `ev_tx_rdy` bit 4, `ev_tx_udf` bit 10 and `ev_rx_ovr` bit 11. A read of 0x08 returns these bits, with the live `bus_busy` input in bit 12.
- R4: A write to 0x08 clears only the status bits set in (wdata AND 0x27). Bits 3 and 4 are cleared only by `clr_rx_rdy` and `clr_tx_rdy` respectively, or by a vector read.
- R5: An event pulse that arrives in the same cycle as any clear of its bit wins, and the bit ends up set.
- R6: Offset 0x04 stores wdata AND 0x3F. `irq` is high exactly when (status bits 5..0) AND the enable mask is nonzero.
- R7: Offset 0x14 stores only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). In the same write, a 1 in bit 15 clears enable bit 3 and a 1 in bit 7 clears enable bit 4.
- R8: `drq_rx` equals receive DMA enable AND status bit 3. `drq_tx` equals transmit DMA enable AND status bit 4.
- R9: Offset 0x24 stores wdata AND 0xCF87 and drives `ctrl`. A read of 0x10 returns control bit 15 in bit 0.
- R10: Offset 0x18 stores a 16-bit count, 0x28 a 10-bit own address and 0x2C a 10-bit target address. Each reads back at its offset and drives its output port.
- R11: A read of 0x0C returns 1 plus the index of the lowest set bit of (status bits 5..0 AND enable mask), or 0 if none is pending. The same read clears that status bit.
- R12: Reads of offsets without a register (including 0x1C and 0x20) return zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ev_nack | input | 1 | Sequencer: acknowledge missing |
| ev_acc_rdy | input | 1 | Sequencer: access finished |
| ev_rx_rdy | input | 1 | Sequencer: receive data available |
| ev_tx_rdy | input | 1 | Sequencer: transmit data wanted |
| ev_tx_udf | input | 1 | Sequencer: transmit underflow |
| ev_rx_ovr | input | 1 | Sequencer: receive overrun |
| clr_rx_rdy | input | 1 | Sequencer clears receive-ready |
| clr_tx_rdy | input | 1 | Sequencer clears transmit-ready |
| bus_busy | input | 1 | Live bus-busy flag |
| irq | output | 1 | Interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |
| ctrl | output | 16 | Stored control word |
| byte_count | output | 16 | Stored transfer count |
| own_addr | output | 10 | Own address |
| tgt_addr | output | 10 | Target address |

## Verification
The main sweep takes every combination of the four settable low status bits and runs it against all 64 enable masks. For each pair it checks the interrupt line, the status readback with a busy flag that toggles between patterns, the vector code, and the status left after the vector's acknowledge. Because every combination is covered, the sweep catches a wrong priority order, an off-by-one vector code, a clear of the wrong bit, and enable bits that leak past the mask. A second sweep over the same status patterns runs with each DMA enable on and then off, which separates correct gating from crossed directions. Directed cases cover same-cycle set/clear conflicts, attempts by software to clear the hardware-owned bits, field masks, ignored offsets and unmapped offsets.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned OFS_W   = 8;
    localparam int unsigned IEN_W   = 6;
    localparam int unsigned STAT_W  = 16;

    localparam logic [OFS_W-1:0] OFS_REV   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_IEN   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_VEC   = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_SYSST = 8'h10;
    localparam logic [OFS_W-1:0] OFS_BUF   = 8'h14;
    localparam logic [OFS_W-1:0] OFS_CNT   = 8'h18;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h24;
    localparam logic [OFS_W-1:0] OFS_OWN   = 8'h28;
    localparam logic [OFS_W-1:0] OFS_TGT   = 8'h2C;

    localparam int unsigned ST_NACK = 1;
    localparam int unsigned ST_ARDY = 2;
    localparam int unsigned ST_RXR  = 3;
    localparam int unsigned ST_TXR  = 4;
    localparam int unsigned ST_XUDF = 10;
    localparam int unsigned ST_ROVR = 11;
    localparam int unsigned ST_BUSY = 12;

    localparam int unsigned DMA_RX_BIT = 15;
    localparam int unsigned DMA_TX_BIT = 7;
    localparam int unsigned CTRL_EN_BIT = 15;

    localparam logic [STAT_W-1:0] ST_KEEP    = 16'h0C1E;
    localparam logic [STAT_W-1:0] SWCLR_MASK = 16'h0027;
    localparam logic [15:0]       BUF_MASK   = 16'h8080;
    localparam logic [15:0]       CTRL_MASK  = 16'hCF87;

    typedef struct packed {
        logic rx_ovr;
        logic tx_udf;
        logic tx_rdy;
        logic rx_rdy;
        logic acc_rdy;
        logic nack;
    } st_evt_t;

endpackage

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  st_evt_t           evt,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] stat_d, stat_q, set_w;

    always_comb begin
        set_w          = '0;
        set_w[ST_NACK] = evt.nack;
        set_w[ST_ARDY] = evt.acc_rdy;
        set_w[ST_RXR]  = evt.rx_rdy;
        set_w[ST_TXR]  = evt.tx_rdy;
        set_w[ST_XUDF] = evt.tx_udf;
        set_w[ST_ROVR] = evt.rx_ovr;
        // set has priority over every clear source
        stat_d = ((stat_q & ~clr_mask) | set_w) & ST_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat = stat_q;
endmodule

// File: rtl/i2c_low_vec.sv
module i2c_low_vec #(
    parameter int unsigned N  = 6,
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend,
    output logic [N-1:0]  onehot,
    output logic [CW-1:0] code
);
    logic [N-1:0] none_below;

    assign none_below[0] = 1'b1;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign onehot[g] = pend[g] & none_below[g];
        if (g < N - 1) begin : g_nx
            assign none_below[g+1] = none_below[g] & ~pend[g];
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) code = CW'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
    import i2c_regs_pkg::*;
#(
    parameter logic [15:0] REV     = 16'h0034,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned SADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic               ev_nack,
    input  logic               ev_acc_rdy,
    input  logic               ev_rx_rdy,
    input  logic               ev_tx_rdy,
    input  logic               ev_tx_udf,
    input  logic               ev_rx_ovr,
    input  logic               clr_rx_rdy,
    input  logic               clr_tx_rdy,
    input  logic               bus_busy,
    output logic               irq,
    output logic               drq_rx,
    output logic               drq_tx,
    output logic [15:0]        ctrl,
    output logic [CNT_W-1:0]   byte_count,
    output logic [SADDR_W-1:0] own_addr,
    output logic [SADDR_W-1:0] tgt_addr
);
    localparam int unsigned VCW = $clog2(IEN_W + 1);

    typedef struct packed {
        logic [IEN_W-1:0]   ie;
        logic [15:0]        dma;
        logic [CNT_W-1:0]   cnt;
        logic [15:0]        ctrl;
        logic [SADDR_W-1:0] oa;
        logic [SADDR_W-1:0] sa;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t             r_d, r_q;
    logic [STAT_W-1:0] stat_w, clr_w, sw_clr, vec_clr, stat_rd;
    logic [IEN_W-1:0]  pend_w, pend_hot;
    logic [VCW-1:0]    vec_code;
    logic [IEN_W-1:0]  ie_w;
    logic [15:0]       dma_w;
    st_evt_t           evt_w;
    logic              unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:16];

    assign evt_w = '{rx_ovr: ev_rx_ovr, tx_udf: ev_tx_udf, tx_rdy: ev_tx_rdy,
                     rx_rdy: ev_rx_rdy, acc_rdy: ev_acc_rdy, nack: ev_nack};

    assign pend_w = stat_w[IEN_W-1:0] & r_q.ie;

    i2c_low_vec #(.N(IEN_W)) u_vec (
        .pend   (pend_w),
        .onehot (pend_hot),
        .code   (vec_code)
    );

    always_comb begin
        clr_w          = sw_clr | vec_clr;
        clr_w[ST_RXR]  = clr_w[ST_RXR] | clr_rx_rdy;
        clr_w[ST_TXR]  = clr_w[ST_TXR] | clr_tx_rdy;
    end

    i2c_stat_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .clr_mask (clr_w),
        .stat     (stat_w)
    );

    always_comb begin
        stat_rd          = stat_w;
        stat_rd[ST_BUSY] = bus_busy;
    end

    always_comb begin
        r_d     = r_q;
        sw_clr  = '0;
        vec_clr = '0;
        if (wr_en) begin
            unique case (addr)
                OFS_IEN:  r_d.ie = wdata[IEN_W-1:0];
                OFS_STAT: sw_clr = wdata[STAT_W-1:0] & SWCLR_MASK;
                OFS_BUF: begin
                    r_d.dma = wdata[15:0] & BUF_MASK;
                    if (wdata[DMA_RX_BIT]) r_d.ie[ST_RXR] = 1'b0;
                    if (wdata[DMA_TX_BIT]) r_d.ie[ST_TXR] = 1'b0;
                end
                OFS_CNT:  r_d.cnt  = wdata[CNT_W-1:0];
                OFS_CTRL: r_d.ctrl = wdata[15:0] & CTRL_MASK;
                OFS_OWN:  r_d.oa   = wdata[SADDR_W-1:0];
                OFS_TGT:  r_d.sa   = wdata[SADDR_W-1:0];
                default: ;
            endcase
        end
        if (rd_en) begin
            unique case (addr)
                OFS_REV:   r_d.rdata = DATA_W'(REV);
                OFS_IEN:   r_d.rdata = DATA_W'(r_q.ie);
                OFS_STAT:  r_d.rdata = DATA_W'(stat_rd);
                OFS_VEC: begin
                    r_d.rdata = DATA_W'(vec_code);
                    vec_clr   = STAT_W'(pend_hot);
                end
                OFS_SYSST: r_d.rdata = DATA_W'(r_q.ctrl[CTRL_EN_BIT]);
                OFS_BUF:   r_d.rdata = DATA_W'(r_q.dma);
                OFS_CNT:   r_d.rdata = DATA_W'(r_q.cnt);
                OFS_CTRL:  r_d.rdata = DATA_W'(r_q.ctrl);
                OFS_OWN:   r_d.rdata = DATA_W'(r_q.oa);
                OFS_TGT:   r_d.rdata = DATA_W'(r_q.sa);
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign ie_w       = r_q.ie;
    assign dma_w      = r_q.dma;
    assign rdata      = r_q.rdata;
    assign irq        = |pend_w;
    assign drq_rx     = r_q.dma[DMA_RX_BIT] & stat_w[ST_RXR];
    assign drq_tx     = r_q.dma[DMA_TX_BIT] & stat_w[ST_TXR];
    assign ctrl       = r_q.ctrl;
    assign byte_count = r_q.cnt;
    assign own_addr   = r_q.oa;
    assign tgt_addr   = r_q.sa;
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
module i2c_ctrl_regs_chk
    import i2c_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        addr,
    input logic [31:0]       wdata,
    input logic              ev_nack,
    input logic              clr_rx_rdy,
    input logic [STAT_W-1:0] stat,
    input logic [IEN_W-1:0]  ie,
    input logic [15:0]       dma,
    input logic              irq,
    input logic              drq_rx,
    input logic              drq_tx
);
    p_rxr_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (stat[ST_RXR] && !clr_rx_rdy && !(rd_en && addr == OFS_VEC)) |=> stat[ST_RXR]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        ev_nack |=> stat[ST_NACK]);

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (ie == '0) |-> !irq);

    p_buf_drops_ie_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_BUF && wdata[DMA_RX_BIT]) |=> !ie[ST_RXR]);

    p_drq_rx_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !dma[DMA_RX_BIT] |-> !drq_rx);

    p_drq_tx_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !dma[DMA_TX_BIT] |-> !drq_tx);
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .ev_nack    (ev_nack),
    .clr_rx_rdy (clr_rx_rdy),
    .stat       (stat_w),
    .ie         (ie_w),
    .dma        (dma_w),
    .irq        (irq),
    .drq_rx     (drq_rx),
    .drq_tx     (drq_tx)
);

// File: tb/tb_i2c_ctrl_regs.sv
module tb_i2c_ctrl_regs;
    localparam logic [15:0] REV = 16'h0034;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic ev_nack = 0, ev_acc_rdy = 0, ev_rx_rdy = 0, ev_tx_rdy = 0, ev_tx_udf = 0, ev_rx_ovr = 0;
    logic clr_rx_rdy = 0, clr_tx_rdy = 0, bus_busy = 0;
    logic irq, drq_rx, drq_tx;
    logic [15:0] ctrl, byte_count;
    logic [9:0] own_addr, tgt_addr;

    int total = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_ctrl_regs #(.REV(REV)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_nack(ev_nack), .ev_acc_rdy(ev_acc_rdy),
        .ev_rx_rdy(ev_rx_rdy), .ev_tx_rdy(ev_tx_rdy), .ev_tx_udf(ev_tx_udf),
        .ev_rx_ovr(ev_rx_ovr), .clr_rx_rdy(clr_rx_rdy), .clr_tx_rdy(clr_tx_rdy),
        .bus_busy(bus_busy), .irq(irq), .drq_rx(drq_rx), .drq_tx(drq_tx),
        .ctrl(ctrl), .byte_count(byte_count), .own_addr(own_addr), .tgt_addr(tgt_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    // e[0] nack, e[1] acc_rdy, e[2] rx_rdy, e[3] tx_rdy, e[4] tx_udf, e[5] rx_ovr
    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        {ev_rx_ovr, ev_tx_udf, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack} = e;
        @(negedge clk);
        {ev_rx_ovr, ev_tx_udf, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack} = '0;
    endtask

    task automatic clear_low;
        wr(8'h08, 32'h27);
        @(negedge clk); clr_rx_rdy = 1; clr_tx_rdy = 1;
        @(negedge clk); clr_rx_rdy = 0; clr_tx_rdy = 0;
    endtask

    function automatic logic [3:0] low_code(input logic [5:0] m);
        for (int i = 0; i < 6; i++) if (m[i]) return 4'(i + 1);
        return 4'd0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 drq", {30'b0, drq_rx, drq_tx}, 0);
        chk("R1 ctrl", {16'b0, ctrl}, 0);
        rd(8'h00, d); chk("R1 rev", d, {16'b0, REV});
        rd(8'h08, d); chk("R1 stat", d, 0);
        rd(8'h04, d); chk("R1 ien", d, 0);
        rd(8'h18, d); chk("R1 cnt", d, 0);

        // R6 enable mask width
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R6 ien mask", d, 32'h3F);

        // R7 buffer config and enable drop
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); chk("R7 buf mask", d, 32'h8080);
        rd(8'h04, d); chk("R7 ien drop", d, 32'h27);
        wr(8'h04, 32'h3F);
        wr(8'h14, 32'h0000_0080);
        rd(8'h04, d); chk("R7 ien tx only", d, 32'h2F);
        wr(8'h14, 0);

        // R9 control and module status
        wr(8'h24, 32'hFFFF_FFFF);
        chk("R9 ctrl port", {16'b0, ctrl}, 32'hCF87);
        rd(8'h24, d); chk("R9 ctrl read", d, 32'hCF87);
        rd(8'h10, d); chk("R9 sysst", d, 1);
        wr(8'h24, 32'h0000_7FFF);
        rd(8'h10, d); chk("R9 sysst off", d, 0);

        // R10 count and addresses
        wr(8'h18, 32'h1234_ABCD);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'h0000_0155);
        chk("R10 cnt port", {16'b0, byte_count}, 32'hABCD);
        rd(8'h18, d); chk("R10 cnt read", d, 32'hABCD);
        rd(8'h28, d); chk("R10 own", d, 32'h3FF);
        rd(8'h2C, d); chk("R10 tgt", d, 32'h155);
        chk("R10 addr ports", {12'b0, own_addr, tgt_addr}, {12'b0, 10'h3FF, 10'h155});

        // R2 ignored offsets
        wr(8'h04, 32'h02);
        pulse(6'b000001);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R2 rev", d, {16'b0, REV});
        rd(8'h08, d); chk("R2 stat kept", d, 32'h02);
        rd(8'h04, d); chk("R2 ien kept", d, 32'h02);
        rd(8'h10, d); chk("R2 sysst kept", d, 0);
        chk("R2 irq kept", {31'b0, irq}, 1);

        // R12 unmapped offsets
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R12 read 1C", d, 0);
        rd(8'h20, d); chk("R12 read 20", d, 0);
        rd(8'h24, d); chk("R12 ctrl kept", d, 32'h4F87);
        rd(8'h18, d); chk("R12 cnt kept", d, 32'hABCD);

        // R4 software cannot clear ready bits; R5 set beats clear
        clear_low;
        pulse(6'b001111);
        wr(8'h08, 32'hFFFF);
        rd(8'h08, d); chk("R4 sw clear", d, 32'h18);
        @(negedge clk); clr_rx_rdy = 1;
        @(negedge clk); clr_rx_rdy = 0;
        rd(8'h08, d); chk("R4 hw clear rx", d, 32'h10);
        @(negedge clk); clr_tx_rdy = 1; ev_tx_rdy = 1;
        @(negedge clk); clr_tx_rdy = 0; ev_tx_rdy = 0;
        rd(8'h08, d); chk("R5 tx set wins", d, 32'h10);
        @(negedge clk); wr_en = 1; addr = 8'h08; wdata = 32'h02; ev_nack = 1;
        @(negedge clk); wr_en = 0; ev_nack = 0;
        rd(8'h08, d); chk("R5 nack set wins", d, 32'h12);

        // R3 high status bits and busy
        pulse(6'b110000);
        bus_busy = 1;
        rd(8'h08, d); chk("R3 high bits busy", d, 32'h1C12);
        bus_busy = 0;

        // R8 DMA request sweep
        for (int dm = 0; dm < 4; dm++) begin
            wr(8'h14, {16'b0, dm[1], 7'b0, dm[0], 7'b0});
            for (int p = 0; p < 16; p++) begin
                clear_low;
                pulse({2'b00, p[3:0]});
                chk("R8 drq_rx", {31'b0, drq_rx}, {31'b0, dm[1] & p[2]});
                chk("R8 drq_tx", {31'b0, drq_tx}, {31'b0, dm[0] & p[3]});
            end
        end
        wr(8'h14, 0);

        // R6/R11/R3 exhaustive sweep of low status vs enable mask
        for (int p = 0; p < 16; p++) begin
            for (int ie = 0; ie < 64; ie++) begin
                logic [5:0]  s, m, oh;
                logic [3:0]  c;
                clear_low;
                pulse({2'b00, p[3:0]});
                wr(8'h04, 32'(ie));
                bus_busy = p[0];
                s = {1'b0, p[3:0], 1'b0};
                m = s & 6'(ie);
                c = low_code(m);
                oh = (c == 0) ? 6'b0 : 6'(1 << (c - 1));
                chk("R6 irq", {31'b0, irq}, {31'b0, |m});
                rd(8'h08, d); chk("R3 stat", d, 32'h0C00 | 32'(s) | (32'(p[0]) << 12));
                rd(8'h0C, d); chk("R11 vec", d, 32'(c));
                rd(8'h08, d); chk("R11 acked", d, 32'h0C00 | 32'(s & ~oh) | (32'(p[0]) << 12));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule